// File: doc/BRIEF.md
# Significance-Compressed Byte-Serial Adder

This block adds two 32-bit integers that arrive in significance-compressed form. Each operand comes as four data bytes and a four-bit mask. A set mask bit means the byte at that position carries real data. A clear bit means the byte is redundant: its value is the sign extension of the decoded byte directly below it, and its data lanes are ignored. Byte 0 is always taken as significant, whatever its mask bit says.

The adder works on one byte position per clock, from the lowest byte upward. Before it does any arithmetic, it classifies the position by how many operands carry real data there:

- **Both significant:** the full byte adder is enabled.
- **One significant:** the significant byte is passed through, incremented or decremented, depending on the filler byte (0x00 or 0xFF) and the incoming carry.
- **Neither significant:** the result byte is derived from the two extension polarities and the carry alone.

Each result byte is then flagged significant unless it equals the sign extension of the result byte below it. The block also counts how many positions needed the full byte adder, which gives a measure of datapath activity.

A user pulses `start` with both operands valid while the block is idle. `done` rises for one cycle when the last byte has been written. The sum, its mask and the adder count then hold until the next accepted start.

Top module: `sigc_byte_adder`

## Requirements
- R1: After reset `sumOut`, `sumSig`, `addCount` and `done` are all zero.
- R2: A `start` sampled high while idle launches an operation. `done` is high for exactly one cycle, starting after the fifth rising edge counted from the edge that sampled `start` (one load edge plus one edge per byte).
- R3: A `start` sampled while an operation is in progress is ignored. The result, mask and count are those of the operation already running.
- R4: Byte 0 of each operand is significant regardless of mask bit 0. A byte whose mask bit (bit i for byte i, i = 1..3) is 0 decodes as 0x00 or 0xFF, following bit 7 of the decoded byte below, and its data lanes have no effect on the result.
- R5: At a position where both operands are significant, the result byte is the 8-bit sum of both bytes plus the carry, and the carry out is bit 8 of that sum.
- R6: At a position where exactly one operand is significant, the result byte is one of: the significant byte (filler 0x00 with carry 0, or filler 0xFF with carry 1); that byte plus one (filler 0x00 with carry 1); or that byte minus one (filler 0xFF with carry 0). In every case the carry out is correct.
- R7: At a position where neither operand is significant, the result byte depends only on the two extension polarities and the carry. It is marked significant when it differs from the extension of the result byte below, for example when 0x7F + 0x01 needs a 0x00 byte above 0x80.
- R8: When `done` is high, `sumOut` equals the decoded A plus the decoded B, modulo 2^32. The outputs stay unchanged while the block is idle and no start is given.
- R9: When `done` is high, `sumSig` bit 0 is 1. Bit i (i ≥ 1) is 1 exactly when result byte i differs from the sign extension of result byte i−1.
- R10: When `done` is high, `addCount` equals the number of positions at which both operands are significant (byte 0 always counts), and never exceeds 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launches an operation when idle |
| opA | input | 32 | Operand A data bytes, byte i at bits 8i+7..8i |
| sigA | input | 4 | Operand A significance mask, bit i for byte i |
| opB | input | 32 | Operand B data bytes |
| sigB | input | 4 | Operand B significance mask |
| sumOut | output | 32 | Result bytes, all four positions written |
| sumSig | output | 4 | Minimal result significance mask |
| done | output | 1 | One-cycle pulse when the result is complete |
| addCount | output | 3 | Number of positions that used the full byte adder |

## Verification
The assertions take for granted that `start` is driven cleanly and that the inputs settle between clock edges. They make no assumption about the data in non-significant lanes, and no assumption that a mask is a contiguous run of low bits. The stimulus therefore fills every non-significant lane with random data and randomly marks redundant bytes as significant, so that both non-minimal and non-prefix masks are applied. It also drives a second start, with altered operands, in the middle of a running operation.

// File: rtl/sigc_pkg.sv
package sigc_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;   // latch operands and clear results
    logic step;   // process the currently indexed byte
    logic last;   // indexed byte is the top one
  } sigcCtl_t;

  // How many operands carry real data at a position
  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_ONLYA = 2'd1,
    CLS_ONLYB = 2'd2,
    CLS_BOTH  = 2'd3
  } sigcClass_t;

endpackage

// File: rtl/sigc_ctrl.sv
module sigc_ctrl
  import sigc_pkg::*;
#(
  parameter int NB = 4,
  localparam int IW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  output sigcCtl_t      ctl,
  output logic [IW-1:0] idx,
  output logic          busy,
  output logic          done
);

  logic lastPos;
  assign lastPos  = (idx == IW'(NB - 1));
  assign ctl.load = start && !busy;
  assign ctl.step = busy;
  assign ctl.last = busy && lastPos;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      idx  <= '0;
      done <= 1'b0;
    end else begin
      done <= ctl.step && ctl.last;
      if (ctl.load) begin
        busy <= 1'b1;
        idx  <= '0;
      end else if (ctl.step) begin
        if (lastPos) begin
          busy <= 1'b0;
          idx  <= '0;
        end else begin
          idx <= idx + IW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/sigc_datapath.sv
module sigc_datapath
  import sigc_pkg::*;
#(
  parameter int NB = 4,
  parameter int BW = 8,
  localparam int IW = (NB > 1) ? $clog2(NB) : 1,
  localparam int DW = NB * BW,
  localparam int CW = $clog2(NB + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  sigcCtl_t      ctl,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] opA,
  input  logic [NB-1:0] sigA,
  input  logic [DW-1:0] opB,
  input  logic [NB-1:0] sigB,
  output logic [DW-1:0] sumQ,
  output logic [NB-1:0] sigQ,
  output logic [CW-1:0] cntQ
);

  logic [DW-1:0] opAQ, opBQ;
  logic [NB-1:0] sigAQ, sigBQ;
  logic [BW-1:0] prevA, prevB, prevSum;
  logic          carryQ;

  logic [BW-1:0] byteA, byteB, effA, effB;
  logic          aLive, bLive;
  sigcClass_t    cls;
  logic          fullEn;
  logic [BW-1:0] resByte;
  logic          carryOut;
  logic          resSig;

  // one-significant helpers
  logic [BW-1:0] soloByte;
  logic          fillHi;

  always_comb begin
    byteA = opAQ[idx*BW +: BW];
    byteB = opBQ[idx*BW +: BW];
    aLive = (idx == '0) || sigAQ[idx];
    bLive = (idx == '0) || sigBQ[idx];
    effA  = aLive ? byteA : {BW{prevA[BW-1]}};
    effB  = bLive ? byteB : {BW{prevB[BW-1]}};
    cls   = sigcClass_t'({aLive, bLive} == 2'b11 ? CLS_BOTH :
                         aLive ? CLS_ONLYA : bLive ? CLS_ONLYB : CLS_NONE);
    fullEn   = ctl.step && (cls == CLS_BOTH);
    soloByte = aLive ? byteA : byteB;
    fillHi   = aLive ? prevB[BW-1] : prevA[BW-1];
    resByte  = '0;
    carryOut = 1'b0;
    unique case (cls)
      CLS_BOTH: begin
        {carryOut, resByte} = {1'b0, byteA} + {1'b0, byteB} + {{BW{1'b0}}, carryQ};
      end
      CLS_ONLYA, CLS_ONLYB: begin
        if (!fillHi) begin
          resByte  = carryQ ? soloByte + BW'(1) : soloByte;
          carryOut = carryQ && (soloByte == {BW{1'b1}});
        end else begin
          resByte  = carryQ ? soloByte : soloByte - BW'(1);
          carryOut = carryQ || (soloByte != '0);
        end
      end
      default: begin
        unique case ({prevA[BW-1], prevB[BW-1]})
          2'b00:   begin resByte = {{(BW-1){1'b0}}, carryQ}; carryOut = 1'b0;   end
          2'b11:   begin resByte = {{(BW-1){1'b1}}, carryQ}; carryOut = 1'b1;   end
          default: begin resByte = {BW{~carryQ}};            carryOut = carryQ; end
        endcase
      end
    endcase
    resSig = (idx == '0) || (resByte != {BW{prevSum[BW-1]}});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opAQ    <= '0;
      opBQ    <= '0;
      sigAQ   <= '0;
      sigBQ   <= '0;
      prevA   <= '0;
      prevB   <= '0;
      prevSum <= '0;
      carryQ  <= 1'b0;
      sumQ    <= '0;
      sigQ    <= '0;
      cntQ    <= '0;
    end else if (ctl.load) begin
      opAQ    <= opA;
      opBQ    <= opB;
      sigAQ   <= sigA;
      sigBQ   <= sigB;
      prevA   <= '0;
      prevB   <= '0;
      prevSum <= '0;
      carryQ  <= 1'b0;
      sumQ    <= '0;
      sigQ    <= '0;
      cntQ    <= '0;
    end else if (ctl.step) begin
      prevA   <= effA;
      prevB   <= effB;
      prevSum <= resByte;
      carryQ  <= carryOut;
      sumQ[idx*BW +: BW] <= resByte;
      sigQ[idx] <= resSig;
      cntQ    <= cntQ + CW'(fullEn);
    end
  end

endmodule

// File: rtl/sigc_byte_adder.sv
module sigc_byte_adder
  import sigc_pkg::*;
#(
  parameter int NB = 4,
  parameter int BW = 8,
  localparam int IW = (NB > 1) ? $clog2(NB) : 1,
  localparam int DW = NB * BW,
  localparam int CW = $clog2(NB + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [DW-1:0] opA,
  input  logic [NB-1:0] sigA,
  input  logic [DW-1:0] opB,
  input  logic [NB-1:0] sigB,
  output logic [DW-1:0] sumOut,
  output logic [NB-1:0] sumSig,
  output logic          done,
  output logic [CW-1:0] addCount
);

  sigcCtl_t      ctl;
  logic [IW-1:0] idx;
  logic          busy;

  sigc_ctrl #(.NB(NB)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start),
    .ctl(ctl), .idx(idx), .busy(busy), .done(done)
  );

  sigc_datapath #(.NB(NB), .BW(BW)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .idx(idx),
    .opA(opA), .sigA(sigA), .opB(opB), .sigB(sigB),
    .sumQ(sumOut), .sigQ(sumSig), .cntQ(addCount)
  );

endmodule

// File: rtl/sigc_byte_adder_chk.sv
module sigc_byte_adder_chk
  import sigc_pkg::*;
#(
  parameter int NB = 4,
  parameter int BW = 8,
  localparam int DW = NB * BW,
  localparam int CW = $clog2(NB + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          start,
  input logic          busy,
  input sigcCtl_t      ctl,
  input logic          done,
  input logic [DW-1:0] sumOut,
  input logic [NB-1:0] sumSig,
  input logic [CW-1:0] addCount
);

  function automatic logic [NB-1:0] minMask(input logic [DW-1:0] v);
    logic [NB-1:0] m;
    m[0] = 1'b1;
    for (int i = 1; i < NB; i++)
      m[i] = (v[i*BW +: BW] != {BW{v[i*BW-1]}});
    return m;
  endfunction

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2
  done_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && ctl.last) |=> done);

  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !ctl.last) |=> busy);

  // R9
  min_sig_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (sumSig == minMask(sumOut)));

  // R4
  low_sig_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> sumSig[0]);

  // R10
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    addCount <= CW'(NB));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(sumOut) && $stable(sumSig) && $stable(addCount)));

endmodule

bind sigc_byte_adder sigc_byte_adder_chk #(.NB(NB), .BW(BW)) chk_i (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .ctl(ctl),
  .done(done), .sumOut(sumOut), .sumSig(sumSig), .addCount(addCount)
);

// File: tb/sigc_byte_adder_tb_top.sv
module sigc_byte_adder_tb_top;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic [3:0]  sigA = '0, sigB = '0;
  logic [31:0] sumOut;
  logic [3:0]  sumSig;
  logic        done;
  logic [2:0]  addCount;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_P/2) clk = ~clk;

  sigc_byte_adder dut_i (
    .clk(clk), .rstN(rstN), .start(start),
    .opA(opA), .sigA(sigA), .opB(opB), .sigB(sigB),
    .sumOut(sumOut), .sumSig(sumSig), .done(done), .addCount(addCount)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] minimal(input logic [31:0] v);
    logic [3:0] m;
    m[0] = 1'b1;
    for (int i = 1; i < 4; i++) m[i] = (v[8*i +: 8] != {8{v[8*i-1]}});
    return m;
  endfunction

  // returns {mask, bytes}; redundant lanes get random junk
  function automatic logic [35:0] compress(input logic [31:0] v, input logic [3:0] extra);
    logic [3:0]  m;
    logic [31:0] d;
    m = minimal(v) | extra;
    if ($urandom_range(0, 1) == 1) m[0] = 1'b0;  // bit 0 mask is a don't-care
    for (int i = 0; i < 4; i++)
      d[8*i +: 8] = (i == 0 || m[i]) ? v[8*i +: 8] : 8'($urandom);
    return {m, d};
  endfunction

  function automatic logic [31:0] rndVal();
    int w;
    logic [31:0] r;
    w = $urandom_range(1, 4);
    r = $urandom;
    if (w < 4) r = 32'($signed(r << (32 - 8*w)) >>> (32 - 8*w));
    return r;
  endfunction

  task automatic runOp(input string req, input logic [31:0] a, input logic [31:0] b,
                       input logic [3:0] exA, input logic [3:0] exB, input bit poke);
    logic [35:0] ca, cb;
    logic [3:0]  live;
    logic [31:0] expSum;
    ca = compress(a, exA);
    cb = compress(b, exB);
    live = (ca[35:32] & cb[35:32]) | 4'b0001;
    expSum = a + b;
    @(negedge clk);
    opA = ca[31:0]; sigA = ca[35:32];
    opB = cb[31:0]; sigB = cb[35:32];
    start = 1'b1;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      start = poke && (k == 2);          // R3: start while busy
      if (poke && k == 2) begin opA = ~opA; opB = 32'h1234_5678; sigA = 4'hF; sigB = 4'hF; end
      check("R2 done timing", {31'd0, done}, {31'd0, k == 5});
    end
    check({req, " sum"}, sumOut, expSum);
    check("R9 mask", {28'd0, sumSig}, {28'd0, minimal(expSum)});
    check("R10 count", {29'd0, addCount}, {29'd0, 3'($countones(live))});
    if (poke) check("R3 busy start ignored", sumOut, expSum);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    check("R1 sum reset", sumOut, 32'h0);
    check("R1 mask reset", {28'd0, sumSig}, 32'h0);
    check("R1 count reset", {29'd0, addCount}, 32'h0);
    check("R1 done reset", {31'd0, done}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", sumOut, 32'h0);

    runOp("R5 both", 32'h1234_5678, 32'h7654_3210, 4'h0, 4'h0, 1'b0);
    runOp("R6 plus one", 32'h0000_00FF, 32'h0000_0001, 4'h0, 4'h0, 1'b0);
    runOp("R6 minus one", 32'h0000_1200, 32'hFFFF_FFFF, 4'h0, 4'h0, 1'b0);
    runOp("R6 pass", 32'h0000_3456, 32'h0000_0010, 4'h0, 4'h0, 1'b0);
    runOp("R7 exceptional", 32'h0000_007F, 32'h0000_0001, 4'h0, 4'h0, 1'b0);
    runOp("R7 neg exceptional", 32'hFFFF_FF80, 32'hFFFF_FFFF, 4'h0, 4'h0, 1'b0);
    runOp("R7 wrap", 32'hFFFF_FFFF, 32'h0000_0001, 4'h0, 4'h0, 1'b0);
    runOp("R8 overflow", 32'h7FFF_FFFF, 32'h0000_0001, 4'h0, 4'h0, 1'b0);
    runOp("R8 modulo", 32'h8000_0000, 32'hFFFF_FFFF, 4'h0, 4'h0, 1'b0);
    runOp("R4 zero", 32'h0, 32'h0, 4'h0, 4'h0, 1'b0);
    runOp("R4 redundant marked", 32'hFFFF_FFF0, 32'h0000_0020, 4'hA, 4'h6, 1'b0);
    runOp("R3 poke", 32'h0000_0100, 32'hFFFF_FF01, 4'h0, 4'h0, 1'b1);

    for (int n = 0; n < 400; n++)
      runOp("R8 random", rndVal(), rndVal(), 4'($urandom), ($urandom_range(0, 3) == 0) ? 4'h0 : 4'($urandom),
            ($urandom_range(0, 7) == 0));

    // R8: outputs hold while idle
    begin
      logic [31:0] held;
      held = sumOut;
      repeat (4) @(negedge clk);
      check("R8 idle hold", sumOut, held);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule